// File: doc/BRIEF.md
# Serial Stereo Audio Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The stream is a bit clock, a word clock that marks left and right halves, and a data line. All three lines are brought into the system clock domain through synchronizer chains. The block finds the rising edges of the bit clock and shifts in data MSB first. Whenever a word-clock half ends, it decodes the word that half carried. Once a right word completes a frame that started with a left word, it presents both 24-bit samples together with a one-cycle valid strobe.

Three run-time settings select the decoding. The first picks the format: right-justified, or I2S with a one-bit delay. The second picks the word length: 16, 20 or 24 bits. The third picks which word-clock level carries the left channel. A new setting is only taken over at a frame boundary, so a frame is never decoded with mixed settings.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, out_valid is low and both samples are zero. Until the first frame boundary that follows arming, the active settings are: right-justified, 16 bits, left on word clock high. These hold whatever the configuration inputs are.
- R2: In right-justified mode (cfg_i2s=0), the word is the last N bits of the half, with its LSB on the final bit-clock rise before the word clock changes. Earlier bits of the half are ignored, and the word is sign-extended to 24 bits.
- R3: In I2S mode (cfg_i2s=1), the rise on which the new word-clock level is first seen carries no data of the new word. The MSB comes on the next rise and is followed by N-1 more bits. Later bits are ignored. The word is placed in the top N bits of the output, with the lower 24-N bits set to zero.
- R4: cfg_len selects N: code 0 gives 16 bits, code 1 gives 20 bits, and codes 2 and 3 give 24 bits.
- R5: With cfg_lpol=0 the left channel is carried while the word clock is high. With cfg_lpol=1 it is carried while the word clock is low.
- R6: Data and word clock are sampled on bit-clock rising edges, MSB first, in two's complement.
- R7: out_valid pulses for exactly one cycle when a right word completes a frame whose left word was captured. A right word with no preceding left word in the same frame produces no pulse.
- R8: The configuration inputs are latched only at a frame boundary. A frame boundary is a word-clock edge into the left level, judged under the polarity already in force. The half that ends at that edge is decoded with the old settings.
- R9: The first word-clock edge after reset only arms the receiver. The half that ends at that edge produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bck | input | 1 | Serial bit clock (asynchronous) |
| wck | input | 1 | Word clock, marks channel halves (asynchronous) |
| sdin | input | 1 | Serial data line |
| cfg_i2s | input | 1 | 0 = right-justified, 1 = I2S |
| cfg_len | input | 2 | Word length code (0:16, 1:20, 2/3:24) |
| cfg_lpol | input | 1 | 0 = left on word clock high, 1 = left on low |
| out_left | output | 24 | Left sample |
| out_right | output | 24 | Right sample |
| out_valid | output | 1 | One-cycle strobe when a stereo pair is presented |

## Verification
The assertions check several properties on every cycle. The detected bit-clock rise never lasts two cycles. The active settings move only on a frame-boundary event. No word is emitted before the receiver is armed. Every valid strobe is one cycle long and is preceded by a captured left word. Only the bench's scenarios can show that the decoded values are right. It sends frames with random slot lengths and junk filler bits, and compares sign extension and left alignment against its own model. It also covers the deferred switch of format, length and polarity, including the filler half that a polarity change needs, and the default decoding of the first frame.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int SAMPLE_W = 24;

  typedef struct packed {
    logic       i2s;
    logic [1:0] len;
    logic       lpol;
  } asr_cfg_t;

  localparam asr_cfg_t CFG_DEFAULT = '{i2s: 1'b0, len: 2'd0, lpol: 1'b0};

  function automatic logic [4:0] len_bits(input logic [1:0] code);
    case (code)
      2'd0:    len_bits = 5'd16;
      2'd1:    len_bits = 5'd20;
      default: len_bits = 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/asr_edge_sync.sv
module asr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_i,
  input  logic wck_i,
  input  logic sd_i,
  output logic rise_o,
  output logic wck_o,
  output logic sd_o
);
  logic [STAGES-1:0][2:0] pipe;
  logic                   bck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe   <= '0;
      bck_q  <= 1'b0;
      rise_o <= 1'b0;
      wck_o  <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      pipe[0] <= {bck_i, wck_i, sd_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bck_q  <= pipe[STAGES-1][2];
      rise_o <= pipe[STAGES-1][2] & ~bck_q;
      wck_o  <= pipe[STAGES-1][1];
      sd_o   <= pipe[STAGES-1][0];
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) rise_o |=> !rise_o); // R6
endmodule

// File: rtl/asr_deser.sv
module asr_deser
  import asr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_i,
  input  logic                wck_i,
  input  logic                sd_i,
  input  asr_cfg_t            cfg_in,
  output logic                word_v,
  output logic                word_left,
  output logic [SAMPLE_W-1:0] word
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  asr_cfg_t            cfg_act;
  logic                wck_q;
  logic                armed;
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] cap;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] dec;
  logic [CNT_W-1:0]    nbits;
  logic                edge_seen;
  logic                bnd;

  assign nbits     = CNT_W'(len_bits(cfg_act.len));
  assign edge_seen = rise_i && (wck_i != wck_q);
  assign bnd       = edge_seen && armed && (wck_i ^ cfg_act.lpol);

  always_comb begin
    case (cfg_act.len)
      2'd0: dec = cfg_act.i2s ? {cap[15:0], 8'd0} : {{8{sh[15]}}, sh[15:0]};
      2'd1: dec = cfg_act.i2s ? {cap[19:0], 4'd0} : {{4{sh[19]}}, sh[19:0]};
      default: dec = cfg_act.i2s ? cap : sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_act   <= CFG_DEFAULT;
      wck_q     <= 1'b0;
      armed     <= 1'b0;
      sh        <= '0;
      cap       <= '0;
      cnt       <= CNT_MAX;
      word_v    <= 1'b0;
      word_left <= 1'b0;
      word      <= '0;
    end else begin
      word_v <= 1'b0;
      if (rise_i) begin
        wck_q <= wck_i;
        sh    <= {sh[SAMPLE_W-2:0], sd_i};
        if (edge_seen) begin
          cnt   <= CNT_W'(1);
          cap   <= '0;
          armed <= 1'b1;
          if (armed) begin
            word_v    <= 1'b1;
            word_left <= wck_q ^ cfg_act.lpol;
            word      <= dec;
          end
          if (bnd) cfg_act <= cfg_in;
        end else begin
          if (cnt != '0 && cnt <= nbits) cap <= {cap[SAMPLE_W-2:0], sd_i};
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CFG_HOLD:   assert property (@(posedge clk) disable iff (rst) !bnd |=> $stable(cfg_act)); // R8
  AST_WORD_ARMED: assert property (@(posedge clk) disable iff (rst) word_v |-> armed);          // R9
endmodule

// File: rtl/asr_pair.sv
module asr_pair
  import asr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                word_v,
  input  logic                word_left,
  input  logic [SAMPLE_W-1:0] word,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                out_valid
);
  logic [SAMPLE_W-1:0] held_l;
  logic                have_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_l    <= '0;
      have_l    <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (word_v) begin
        if (word_left) begin
          held_l <= word;
          have_l <= 1'b1;
        end else begin
          have_l <= 1'b0;
          if (have_l) begin
            out_left  <= held_l;
            out_right <= word;
            out_valid <= 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_SINGLE:  assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);      // R7
  AST_LEFT_BEFORE_R: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(have_l));   // R7
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bck,
  input  logic        wck,
  input  logic        sdin,
  input  logic        cfg_i2s,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_lpol,
  output logic [23:0] out_left,
  output logic [23:0] out_right,
  output logic        out_valid
);
  logic                rise_s, wck_s, sd_s;
  logic                word_v, word_left;
  logic [SAMPLE_W-1:0] word;
  asr_cfg_t            cfg_in;

  assign cfg_in = '{i2s: cfg_i2s, len: cfg_len, lpol: cfg_lpol};

  asr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bck_i(bck), .wck_i(wck), .sd_i(sdin),
    .rise_o(rise_s), .wck_o(wck_s), .sd_o(sd_s)
  );

  asr_deser #(.CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst(rst), .rise_i(rise_s), .wck_i(wck_s), .sd_i(sd_s),
    .cfg_in(cfg_in), .word_v(word_v), .word_left(word_left), .word(word)
  );

  asr_pair u_pair (
    .clk(clk), .rst(rst), .word_v(word_v), .word_left(word_left), .word(word),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
  );
endmodule

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b0, wck = 1'b0, sdin = 1'b0;
  logic        cfg_i2s = 1'b0, cfg_lpol = 1'b0;
  logic [1:0]  cfg_len = 2'd0;
  logic [23:0] out_left, out_right;
  logic        out_valid;

  int total = 0, bad = 0;
  int wr = 0, rd = 0, pulses = 0;
  logic [23:0] ql [0:127];
  logic [23:0] qr [0:127];
  logic act_i2s = 1'b0, act_lpol = 1'b0, cur_wck = 1'b0, prev_v = 1'b0, done = 1'b0;
  logic [1:0] act_len = 2'd0;

  always #2 clk = ~clk;

  audio_serial_rx uut (
    .clk(clk), .rst(rst), .bck(bck), .wck(wck), .sdin(sdin),
    .cfg_i2s(cfg_i2s), .cfg_len(cfg_len), .cfg_lpol(cfg_lpol),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
  );

  function automatic int nb_of(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] expect_word(input logic [31:0] s, input int nb, input logic i2s);
    logic [31:0] mask, m;
    mask = (32'd1 << nb) - 1;
    m = s & mask;
    if (i2s) return 24'(m << (24 - nb));
    if (m[nb-1]) m = m | ~mask;
    return m[23:0];
  endfunction

  task automatic check(input logic ok, input string what, input logic [23:0] got, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic bit_out(input logic b, input logic w);
    @(negedge clk);
    wck = w; sdin = b; bck = 1'b0;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic lvl, input logic [31:0] s, input int nb, input logic i2s, input int slot);
    for (int k = 0; k < slot; k++) begin
      logic b;
      b = 1'($urandom);
      if (i2s && k >= 1 && k <= nb) b = s[nb-k];
      if (!i2s && k >= slot - nb) b = s[slot-1-k];
      bit_out(b, lvl);
    end
    cur_wck = lvl;
  endtask

  task automatic send_frame(input logic [31:0] sl, input logic [31:0] sr,
                            input logic n_i2s, input logic [1:0] n_len, input logic n_lpol);
    int nb, slot;
    logic lvl;
    nb  = nb_of(act_len);
    lvl = ~act_lpol;
    if (cur_wck == lvl) send_half(~lvl, $urandom, nb, act_i2s, nb + 2);
    ql[wr] = expect_word(sl, nb, act_i2s);
    qr[wr] = expect_word(sr, nb, act_i2s);
    wr++;
    slot = nb + 1 + int'($urandom % 8);
    send_half(lvl, sl, nb, act_i2s, slot);
    cfg_i2s = n_i2s; cfg_len = n_len; cfg_lpol = n_lpol;
    slot = nb + 1 + int'($urandom % 8);
    send_half(~lvl, sr, nb, act_i2s, slot);
    act_i2s = n_i2s; act_len = n_len; act_lpol = n_lpol;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && prev_v) check(1'b0, "R7 strobe longer than one cycle", 24'd1, 24'd0);
      if (out_valid) begin
        pulses++;
        if (rd >= wr) check(1'b0, "R7 R9 unexpected strobe", 24'(rd), 24'(wr));
        else begin
          check(out_left == ql[rd], $sformatf("R2 R3 R4 R5 R6 R8 left frame %0d", rd), out_left, ql[rd]);
          check(out_right == qr[rd], $sformatf("R2 R3 R4 R5 R6 R8 right frame %0d", rd), out_right, qr[rd]);
          rd++;
        end
      end
      prev_v = out_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    cfg_i2s = 1'b1; cfg_len = 2'd2; cfg_lpol = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", {23'd0, out_valid}, 24'd0);
    check(out_left == 24'd0, "R1 left after reset", out_left, 24'd0);
    check(out_right == 24'd0, "R1 right after reset", out_right, 24'd0);
    // R9: dummy half before the arming edge produces nothing
    send_half(1'b0, 32'h1234, 16, 1'b0, 10);
    // R1: first frame uses defaults despite I2S/24/low-left inputs
    send_frame(32'h8000, 32'h7FFF, 1'b1, 2'd2, 1'b0);
    // R3 R4 R8: 24-bit I2S extremes, then 20-bit normal with flipped polarity (R5)
    send_frame(32'h800000, 32'h7FFFFF, 1'b0, 2'd1, 1'b1);
    send_frame(32'h80000, 32'h00001, 1'b1, 2'd0, 1'b1);
    send_frame(32'hFFFF, 32'h8001, 1'b0, 2'd3, 1'b0);
    for (int f = 0; f < 40; f++) begin
      logic [31:0] a, b;
      int nb;
      nb = nb_of(act_len);
      a = $urandom; b = $urandom;
      if (f % 5 == 0) begin a = 32'd1 << (nb - 1); b = (32'd1 << (nb - 1)) - 1; end
      send_frame(a, b, 1'($urandom), 2'($urandom), 1'($urandom));
    end
    send_half(~cur_wck, 32'd0, 16, 1'b0, 3);
    repeat (60) @(negedge clk);
    check(pulses == wr, "R7 R9 strobe count", 24'(pulses), 24'(wr));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule